// File: doc/BRIEF.md
# Source-Selecting Prescaled Bus Clock Divider

This block derives a bus clock enable strobe from one of four source enable strobes. All of them live in a single reference clock domain. A 32-bit control register holds three fields: a source select, a linear pre-divide factor and a power-of-two divide exponent. The linear pre-divider only takes part when source 3 is selected. For the other three sources it is bypassed, and every source then passes through a shared divide-by-2^P stage.

Software writes the control word through a simple write strobe and can read it back at any time. A rate-status output reports the total division ratio currently in force. A new control value is not applied in the middle of an output period. It is adopted when the current period completes, or at once if no period is under way. An output period is therefore never cut short.

Top module: `busclk_prediv`

## Requirements
- R1: After reset the stored control word reads 0, so the select, pre-divide and exponent fields are all zero. The rate status reads 1, `bus_en` is low, and every strobe on source 0 gives one output strobe.
- R2: A write with `wr_en` high stores the masked `wr_data`, and `rd_data` shows it from the next cycle. The stored fields are select at bits 13:12, pre-divide code at bits 7:6 and exponent at bits 5:4. All other bits read as zero.
- R3: Only strobes on `src_en[sel]` advance the divider. Strobes on the unselected sources have no effect on the output.
- R4: The exponent field P divides the post-pre-divider strobe stream by 2^P, for a ratio of 1, 2, 4 or 8.
- R5: When the select is 3, the pre-divide code M divides the source strobe stream by M+1 ahead of the power-of-two stage. The total ratio is then (M+1)·2^P.
- R6: When the select is 0, 1 or 2, the M field has no effect and the ratio is 2^P.
- R7: `bus_en` is high for one cycle, in the cycle after the source strobe that completes an output period. Every output strobe is therefore preceded by a strobe on the active source, and the output never carries more strobes than the source.
- R8: A newly written configuration becomes active only in the cycle that completes an output period, or in a cycle where no partial count is held and the active source is not strobing. No output period is shortened.
- R9: `rate_div` equals the ratio of the active configuration: (M+1)·2^P when the active select is 3, and 2^P otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 4 | Enable strobes of the four candidate sources |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Stored control word, unused bits zero |
| bus_en | output | 1 | Divided bus clock enable strobe |
| rate_div | output | 6 | Total division ratio of the active configuration |

## Verification
A wrong internal count or wrongly captured active field shows up directly on `bus_en`. A strobe appears one source strobe early or late, or it appears on a source that should not count. The first such error appears within one output period, which is at most 32 source strobes. A wrongly adopted configuration also shows up on `rate_div`, in the cycle after the adoption. The bench therefore compares `bus_en`, `rate_div` and `rd_data` against a reference model on every cycle. It also counts output strobes across directed windows, to expose ratio errors that balance out over short stretches.

// File: rtl/busclk_prediv.sv
module busclk_prediv #(
  parameter int DATA_W     = 32,
  parameter int SRC_N      = 4,
  parameter int SEL_LSB    = 12,
  parameter int M_LSB      = 6,
  parameter int M_W        = 2,
  parameter int P_LSB      = 4,
  parameter int P_W        = 2,
  parameter int PREDIV_SRC = 3,
  localparam int SEL_W     = $clog2(SRC_N),
  localparam int POW_CW    = (1 << P_W) - 1,
  localparam int RATE_W    = M_W + (1 << P_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_en,
  output logic [RATE_W-1:0] rate_div
);

  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'(((1 << SEL_W) - 1) << SEL_LSB);
  localparam logic [DATA_W-1:0] M_MASK   = DATA_W'(((1 << M_W) - 1) << M_LSB);
  localparam logic [DATA_W-1:0] P_MASK   = DATA_W'(((1 << P_W) - 1) << P_LSB);
  localparam logic [DATA_W-1:0] CFG_MASK = SEL_MASK | M_MASK | P_MASK;

  logic [DATA_W-1:0] cfg_q;
  logic [SEL_W-1:0]  act_sel;
  logic [M_W-1:0]    act_m;
  logic [P_W-1:0]    act_p;
  logic [M_W-1:0]    pre_cnt;
  logic [POW_CW-1:0] pow_cnt;

  logic src_hit, is_pre, pre_wrap, pre_tick, pow_wrap, out_tick, idle, adopt;
  logic [RATE_W-1:0] pre_fac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data & CFG_MASK;
  end

  assign rd_data  = cfg_q;

  assign src_hit  = src_en[act_sel];
  assign is_pre   = act_sel == SEL_W'(PREDIV_SRC);
  assign pre_wrap = pre_cnt == act_m;
  assign pre_tick = src_hit && (!is_pre || pre_wrap);
  assign pow_wrap = pow_cnt == POW_CW'((1 << act_p) - 1);
  assign out_tick = pre_tick && pow_wrap;
  assign idle     = (pre_cnt == '0) && (pow_cnt == '0) && !src_hit;
  assign adopt    = out_tick || idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (out_tick || (is_pre && src_hit && pre_wrap)) begin
      pre_cnt <= '0;
    end else if (is_pre && src_hit) begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pow_cnt <= '0;
    else if (out_tick) pow_cnt <= '0;
    else if (pre_tick) pow_cnt <= pow_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= '0;
      act_m   <= '0;
      act_p   <= '0;
    end else if (adopt) begin
      act_sel <= cfg_q[SEL_LSB +: SEL_W];
      act_m   <= cfg_q[M_LSB +: M_W];
      act_p   <= cfg_q[P_LSB +: P_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_en <= 1'b0;
    else bus_en <= out_tick;
  end

  assign pre_fac  = is_pre ? RATE_W'(act_m) + RATE_W'(1) : RATE_W'(1);
  assign rate_div = pre_fac << act_p;

endmodule

module busclk_prediv_chk #(
  parameter int DATA_W = 32,
  parameter int SRC_N  = 4,
  parameter int SEL_W  = 2,
  parameter int RATE_W = 6,
  parameter logic [DATA_W-1:0] MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  src_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              bus_en,
  input logic [RATE_W-1:0] rate_div,
  input logic [SEL_W-1:0]  act_sel
);

  AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~MASK) == '0); // R2

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & MASK)); // R2

  AST_OUT_AFTER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> $past(src_en[act_sel])); // R7

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && rate_div > RATE_W'(1)) |=> !bus_en); // R4

  AST_RATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rate_div != '0 && rate_div <= RATE_W'(32)); // R9

endmodule

bind busclk_prediv busclk_prediv_chk #(
  .DATA_W(DATA_W), .SRC_N(SRC_N), .SEL_W(SEL_W), .RATE_W(RATE_W), .MASK(CFG_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .bus_en(bus_en), .rate_div(rate_div), .act_sel(act_sel)
);

// File: tb/busclk_prediv_bench.sv
module busclk_prediv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_en = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        bus_en;
  logic [5:0]  rate_div;

  int checks = 0;
  int errors = 0;
  int n_out  = 0;
  bit done   = 0;

  int m_cfg, m_sel, m_m, m_p, m_pre, m_pow, m_out;

  busclk_prediv u_busclk_prediv (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .bus_en(bus_en), .rate_div(rate_div)
  );

  always #2 clk = ~clk;

  function automatic int exp_rate(int sel, int m, int p);
    return ((sel == 3) ? (m + 1) : 1) << p;
  endfunction

  function automatic int cfg_word(int sel, int m, int p);
    return (sel << 12) | (m << 6) | (p << 4);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_next(input logic [3:0] s, input logic we, input logic [31:0] wd);
    bit sv, pre_t, tk, ld;
    sv    = s[m_sel];
    pre_t = (m_sel == 3) ? (sv && m_pre == m_m) : sv;
    tk    = pre_t && (m_pow == ((1 << m_p) - 1));
    ld    = tk || (m_pre == 0 && m_pow == 0 && !sv);
    if (tk) m_pre = 0;
    else if (m_sel == 3 && sv) m_pre = (m_pre == m_m) ? 0 : m_pre + 1;
    if (tk) m_pow = 0;
    else if (pre_t) m_pow++;
    if (ld) begin
      m_sel = (m_cfg >> 12) & 3;
      m_m   = (m_cfg >> 6) & 3;
      m_p   = (m_cfg >> 4) & 3;
    end
    if (we) m_cfg = int'(wd & 32'h0000_30F0);
    m_out = tk;
  endtask

  task automatic step(input logic [3:0] s, input logic we, input logic [31:0] wd);
    @(negedge clk);
    chk(bus_en === m_out[0], "R7 bus_en", int'(bus_en), m_out);
    chk(int'(rate_div) == exp_rate(m_sel, m_m, m_p), "R9 rate_div",
        int'(rate_div), exp_rate(m_sel, m_m, m_p));
    chk(rd_data == m_cfg, "R2 rd_data", int'(rd_data), m_cfg);
    if (bus_en) n_out++;
    model_next(s, we, wd);
    src_en = s; wr_en = we; wr_data = wd;
  endtask

  task automatic write_cfg(input int w);
    step(4'h0, 1'b1, w);
    step(4'h0, 1'b0, 0);
    step(4'h0, 1'b0, 0);
  endtask

  task automatic pulses(input logic [3:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      step(s, 1'b0, 0);
      step(4'h0, 1'b0, 0);
    end
    step(4'h0, 1'b0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    m_cfg = 0; m_sel = 0; m_m = 0; m_p = 0; m_pre = 0; m_pow = 0; m_out = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(rd_data == 0, "R1 rd_data after reset", int'(rd_data), 0);
    chk(rate_div == 6'd1, "R1 rate_div after reset", int'(rate_div), 1);
    chk(bus_en == 1'b0, "R1 bus_en after reset", int'(bus_en), 0);

    n_out = 0; pulses(4'h1, 5);
    chk(n_out == 5, "R1 source 0 undivided", n_out, 5);

    write_cfg(32'hFFFF_FFFF);
    chk(rd_data == 32'h0000_30F0, "R2 unused bits zero", int'(rd_data), 32'h30F0);

    write_cfg(cfg_word(2, 0, 0));
    n_out = 0; pulses(4'h4, 6);
    chk(n_out == 6, "R3 selected source counts", n_out, 6);
    n_out = 0; pulses(4'hB, 6);
    chk(n_out == 0, "R3 other sources ignored", n_out, 0);

    write_cfg(cfg_word(0, 0, 2));
    n_out = 0; pulses(4'h1, 16);
    chk(n_out == 4, "R4 divide by 4", n_out, 4);

    write_cfg(cfg_word(3, 2, 1));
    n_out = 0; pulses(4'h8, 24);
    chk(n_out == 4, "R5 prediv 3 times 2", n_out, 4);

    write_cfg(cfg_word(3, 3, 3));
    n_out = 0; pulses(4'h8, 31);
    chk(n_out == 0, "R5 no output before 32", n_out, 0);
    pulses(4'h8, 1);
    chk(n_out == 1, "R5 output at 32", n_out, 1);

    write_cfg(cfg_word(1, 3, 0));
    n_out = 0; pulses(4'h2, 10);
    chk(n_out == 10, "R6 M ignored on source 1", n_out, 10);

    write_cfg(cfg_word(0, 0, 3));
    n_out = 0; pulses(4'h1, 4);
    write_cfg(cfg_word(0, 0, 0));
    chk(int'(rate_div) == 8, "R8 change held mid period", int'(rate_div), 8);
    pulses(4'h1, 3);
    chk(n_out == 0, "R8 period not shortened", n_out, 0);
    pulses(4'h1, 1);
    chk(n_out == 1, "R8 period completes at 8", n_out, 1);
    pulses(4'h1, 3);
    chk(n_out == 4, "R8 new ratio after boundary", n_out, 4);

    for (int i = 0; i < 20000; i++) begin
      logic [3:0] s;
      logic we;
      s  = 4'($urandom) & 4'($urandom);
      we = ($urandom % 64) == 0;
      step(s, we, $urandom);
    end
    step(4'h0, 1'b0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule